// File: doc/BRIEF.md
# Stop Mode Selection Controller

This block decides which low-power stop variant a small microcontroller falls into when its CPU executes a STOP instruction, and it runs the wake-up back to normal operation. At the edge where the STOP strobe is seen, it samples five configuration bits: stop enable, debug enable, supply-monitor enable, supply-monitor-in-stop enable and deep power-down select. A fixed priority among these bits gives one of four stop variants, or an illegal-opcode reset request when stop is not enabled. The variant chosen decides which clocks keep running and whether the regulator stays at full strength.

While the block is stopped it watches the reset pin, a set of internal peripheral interrupt lines and a set of pin interrupt lines. A wake returns the mode to run and reports whether the CPU must fetch the reset vector or an interrupt vector. In the deep power-down variant, only the reset pin or a pin interrupt can wake the part, and the fetch is always a reset-vector fetch.

Top module: `stop_mode_ctrl`

## Requirements
- R1: If STOP executes in run mode with stop enable at 0, `illegal_rst` is high for exactly the next cycle and `mode_o` stays 0 (run).
- R2: If STOP executes with stop enable at 1 and debug enable at 1, `mode_o` becomes 3 on the next cycle, whatever the other bits are, and `dbg_clk_en` and `reg_full_en` are both 1 in that mode.
- R3: If STOP executes with stop enable 1, debug enable 0 and both supply-monitor bits at 1, `mode_o` becomes 2. In mode 2 `reg_full_en` and `analog_stop_ok` are 1. `analog_stop_ok` is 0 in every other mode.
- R4: If STOP executes with stop enable 1, debug enable 0 and either supply-monitor bit at 0, `mode_o` becomes 1 when power-down select is 0 and 4 when it is 1. In modes 1 and 4, `reg_full_en` and `dbg_clk_en` are 0.
- R5: After reset, `mode_o` is 0 (run), `cpu_clk_en`, `dbg_clk_en` and `reg_full_en` are 1, and every pulse output is 0.
- R6: The configuration bits are sampled only on the edge of the STOP strobe. Changing them later, or pulsing the strobe again while stopped, leaves `mode_o` unchanged.
- R7: In modes 1, 2 and 3, a high bit on any `int_irq` or `pin_irq` line, with `reset_pin` low, returns `mode_o` to 0 on the next edge and pulses `wake_irq_vec` for one cycle.
- R8: In any stop mode a high `reset_pin` wakes the block on the next edge with `wake_rst_vec` pulsed and `wake_irq_vec` low, even when interrupt lines are high at the same time.
- R9: In mode 4, `int_irq` lines have no effect. Only `reset_pin` or a `pin_irq` line wakes the block, and that wake always pulses `wake_rst_vec`.
- R10: In every stop mode, `cpu_clk_en` is 0 and `io_hold` is 1. In run mode `io_hold` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| stop_exec | input | 1 | One-cycle strobe: the CPU executed STOP |
| cfg_stop_en | input | 1 | Stop enable |
| cfg_dbg_en | input | 1 | Debug enable |
| cfg_lvd_en | input | 1 | Supply monitor enable |
| cfg_lvd_stop_en | input | 1 | Supply monitor kept on in stop |
| cfg_pd_sel | input | 1 | Deep power-down select |
| reset_pin | input | 1 | External reset request, active high |
| int_irq | input | N_INT | Internal peripheral interrupt requests |
| pin_irq | input | N_PIN | Pin interrupt requests |
| mode_o | output | 3 | 0 run, 1 stop3, 2 stop3 regulator on, 3 stop3 debug, 4 stop2 |
| cpu_clk_en | output | 1 | CPU and bus clock enable |
| dbg_clk_en | output | 1 | Debug logic clock enable |
| reg_full_en | output | 1 | Regulator held at full regulation |
| analog_stop_ok | output | 1 | ADC / bandgap comparator allowed to run in stop |
| io_hold | output | 1 | Register, RAM and pin state held |
| illegal_rst | output | 1 | One-cycle illegal-opcode reset request |
| wake_rst_vec | output | 1 | One-cycle pulse: wake through the reset vector |
| wake_irq_vec | output | 1 | One-cycle pulse: wake through an interrupt vector |

## Verification
The bench builds the block with N_INT=5 and N_PIN=3. This keeps the lines few enough that each internal and pin interrupt line can be raised alone, and it still leaves more than one line per group, so the OR over each group is tested. All 32 combinations of the configuration bits are sent through the STOP strobe, which reaches every branch of the priority. Deep power-down is tested with all internal lines raised together, to confirm that they are ignored.

// File: rtl/stopsel_pkg.sv
package stopsel_pkg;

  typedef enum logic [2:0] {
    MODE_RUN       = 3'd0,
    MODE_STOP3     = 3'd1,
    MODE_STOP3_REG = 3'd2,
    MODE_STOP3_DBG = 3'd3,
    MODE_STOP2     = 3'd4
  } mode_e;

  // Priority: stop enable, then debug, then supply monitor pair, then power-down select.
  function automatic mode_e pick_mode(input logic stop_en, input logic dbg_en,
                                      input logic lvd_en, input logic lvd_stop_en,
                                      input logic pd_sel);
    mode_e m;
    if (!stop_en)                  m = MODE_RUN;
    else if (dbg_en)               m = MODE_STOP3_DBG;
    else if (lvd_en && lvd_stop_en) m = MODE_STOP3_REG;
    else if (pd_sel)               m = MODE_STOP2;
    else                           m = MODE_STOP3;
    return m;
  endfunction

endpackage

// File: rtl/stopsel_decode.sv
module stopsel_decode
  import stopsel_pkg::*;
(
  input  logic  stop_en,
  input  logic  dbg_en,
  input  logic  lvd_en,
  input  logic  lvd_stop_en,
  input  logic  pd_sel,
  output mode_e sel_mode,
  output logic  sel_illegal
);
  always_comb begin
    sel_mode    = pick_mode(stop_en, dbg_en, lvd_en, lvd_stop_en, pd_sel);
    sel_illegal = !stop_en;
  end
endmodule

// File: rtl/stopsel_wake.sv
module stopsel_wake
  import stopsel_pkg::*;
#(
  parameter int N_INT = 5,
  parameter int N_PIN = 8
) (
  input  mode_e            mode,
  input  logic             reset_pin,
  input  logic [N_INT-1:0] int_irq,
  input  logic [N_PIN-1:0] pin_irq,
  output logic             wake_any,
  output logic             wake_is_rst
);
  logic int_any, pin_any;

  always_comb begin
    int_any = |int_irq;
    pin_any = |pin_irq;
    wake_any    = 1'b0;
    wake_is_rst = 1'b0;
    unique case (mode)
      MODE_RUN: begin
        wake_any    = 1'b0;
        wake_is_rst = 1'b0;
      end
      MODE_STOP2: begin
        wake_any    = reset_pin | pin_any;
        wake_is_rst = 1'b1;
      end
      default: begin
        wake_any    = reset_pin | pin_any | int_any;
        wake_is_rst = reset_pin;
      end
    endcase
  end
endmodule

// File: rtl/stopsel_gates.sv
module stopsel_gates
  import stopsel_pkg::*;
(
  input  mode_e mode,
  output logic  cpu_clk_en,
  output logic  dbg_clk_en,
  output logic  reg_full_en,
  output logic  analog_stop_ok,
  output logic  io_hold
);
  always_comb begin
    cpu_clk_en     = (mode == MODE_RUN);
    dbg_clk_en     = (mode == MODE_RUN) || (mode == MODE_STOP3_DBG);
    reg_full_en    = (mode == MODE_RUN) || (mode == MODE_STOP3_DBG) ||
                     (mode == MODE_STOP3_REG);
    analog_stop_ok = (mode == MODE_STOP3_REG);
    io_hold        = (mode != MODE_RUN);
  end
endmodule

// File: rtl/stop_mode_ctrl.sv
module stop_mode_ctrl
  import stopsel_pkg::*;
#(
  parameter int N_INT = 5,
  parameter int N_PIN = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_exec,
  input  logic             cfg_stop_en,
  input  logic             cfg_dbg_en,
  input  logic             cfg_lvd_en,
  input  logic             cfg_lvd_stop_en,
  input  logic             cfg_pd_sel,
  input  logic             reset_pin,
  input  logic [N_INT-1:0] int_irq,
  input  logic [N_PIN-1:0] pin_irq,
  output logic [2:0]       mode_o,
  output logic             cpu_clk_en,
  output logic             dbg_clk_en,
  output logic             reg_full_en,
  output logic             analog_stop_ok,
  output logic             io_hold,
  output logic             illegal_rst,
  output logic             wake_rst_vec,
  output logic             wake_irq_vec
);
  mode_e mode_q;
  mode_e sel_mode;
  logic  sel_illegal;
  logic  wake_any;
  logic  wake_is_rst;

  stopsel_decode u_dec (
    .stop_en(cfg_stop_en), .dbg_en(cfg_dbg_en), .lvd_en(cfg_lvd_en),
    .lvd_stop_en(cfg_lvd_stop_en), .pd_sel(cfg_pd_sel),
    .sel_mode(sel_mode), .sel_illegal(sel_illegal)
  );

  stopsel_wake #(.N_INT(N_INT), .N_PIN(N_PIN)) u_wake (
    .mode(mode_q), .reset_pin(reset_pin), .int_irq(int_irq), .pin_irq(pin_irq),
    .wake_any(wake_any), .wake_is_rst(wake_is_rst)
  );

  stopsel_gates u_gates (
    .mode(mode_q), .cpu_clk_en(cpu_clk_en), .dbg_clk_en(dbg_clk_en),
    .reg_full_en(reg_full_en), .analog_stop_ok(analog_stop_ok), .io_hold(io_hold)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q       <= MODE_RUN;
      illegal_rst  <= 1'b0;
      wake_rst_vec <= 1'b0;
      wake_irq_vec <= 1'b0;
    end else begin
      illegal_rst  <= 1'b0;
      wake_rst_vec <= 1'b0;
      wake_irq_vec <= 1'b0;
      if (mode_q == MODE_RUN) begin
        if (stop_exec) begin
          if (sel_illegal) illegal_rst <= 1'b1;
          else             mode_q      <= sel_mode;
        end
      end else if (wake_any) begin
        mode_q       <= MODE_RUN;
        wake_rst_vec <= wake_is_rst;
        wake_irq_vec <= !wake_is_rst;
      end
    end
  end

  assign mode_o = mode_q;

endmodule

// File: rtl/stopsel_checker.sv
module stopsel_checker #(
  parameter int N_PIN = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stop_exec,
  input logic             cfg_stop_en,
  input logic             cfg_dbg_en,
  input logic             cfg_lvd_en,
  input logic             cfg_lvd_stop_en,
  input logic             cfg_pd_sel,
  input logic             reset_pin,
  input logic [N_PIN-1:0] pin_irq,
  input logic [2:0]       mode_o,
  input logic             cpu_clk_en,
  input logic             dbg_clk_en,
  input logic             reg_full_en,
  input logic             analog_stop_ok,
  input logic             io_hold,
  input logic             illegal_rst,
  input logic             wake_rst_vec,
  input logic             wake_irq_vec,
  input logic             wake_any
);
  logic entry;
  assign entry = (mode_o == 3'd0) && stop_exec && cfg_stop_en;

  AST_ILLEGAL_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_o == 3'd0) && stop_exec && !cfg_stop_en) |=> (illegal_rst && mode_o == 3'd0)); // R1
  AST_DBG_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (entry && cfg_dbg_en) |=> (mode_o == 3'd3 && dbg_clk_en && reg_full_en)); // R2
  AST_REG_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (entry && !cfg_dbg_en && cfg_lvd_en && cfg_lvd_stop_en) |=> (mode_o == 3'd2 && analog_stop_ok)); // R3
  AST_PD_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (entry && !cfg_dbg_en && !(cfg_lvd_en && cfg_lvd_stop_en)) |=>
      (mode_o == ($past(cfg_pd_sel) ? 3'd4 : 3'd1) && !reg_full_en)); // R4
  AST_MODE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_o != 3'd0) && !wake_any) |=> $stable(mode_o)); // R6
  AST_WAKE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_o != 3'd0) && wake_any) |=> (mode_o == 3'd0 && $countones({wake_rst_vec, wake_irq_vec}) == 1)); // R7
  AST_RST_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_o != 3'd0) && reset_pin) |=> (wake_rst_vec && !wake_irq_vec)); // R8
  AST_STOP2_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_o == 3'd4) && wake_any) |=> wake_rst_vec); // R9
  AST_STOP2_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_o == 3'd4) && !reset_pin && (pin_irq == '0)) |=> (mode_o == 3'd4)); // R9
  AST_CPU_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o != 3'd0) |-> (!cpu_clk_en && io_hold)); // R10
endmodule

bind stop_mode_ctrl stopsel_checker #(.N_PIN(N_PIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .stop_exec(stop_exec), .cfg_stop_en(cfg_stop_en),
  .cfg_dbg_en(cfg_dbg_en), .cfg_lvd_en(cfg_lvd_en), .cfg_lvd_stop_en(cfg_lvd_stop_en),
  .cfg_pd_sel(cfg_pd_sel), .reset_pin(reset_pin), .pin_irq(pin_irq), .mode_o(mode_o),
  .cpu_clk_en(cpu_clk_en), .dbg_clk_en(dbg_clk_en), .reg_full_en(reg_full_en),
  .analog_stop_ok(analog_stop_ok), .io_hold(io_hold), .illegal_rst(illegal_rst),
  .wake_rst_vec(wake_rst_vec), .wake_irq_vec(wake_irq_vec), .wake_any(wake_any)
);

// File: tb/sim_stop_mode_ctrl.sv
module sim_stop_mode_ctrl;
  localparam int N_INT = 5;
  localparam int N_PIN = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stop_exec = 1'b0;
  logic se = 1'b0, de = 1'b0, le = 1'b0, ls = 1'b0, pd = 1'b0;
  logic reset_pin = 1'b0;
  logic [N_INT-1:0] int_irq = '0;
  logic [N_PIN-1:0] pin_irq = '0;
  logic [2:0] mode_o;
  logic cpu_clk_en, dbg_clk_en, reg_full_en, analog_stop_ok, io_hold;
  logic illegal_rst, wake_rst_vec, wake_irq_vec;

  always #5 clk = ~clk;

  stop_mode_ctrl #(.N_INT(N_INT), .N_PIN(N_PIN)) u0 (
    .clk(clk), .rst_n(rst_n), .stop_exec(stop_exec), .cfg_stop_en(se),
    .cfg_dbg_en(de), .cfg_lvd_en(le), .cfg_lvd_stop_en(ls), .cfg_pd_sel(pd),
    .reset_pin(reset_pin), .int_irq(int_irq), .pin_irq(pin_irq), .mode_o(mode_o),
    .cpu_clk_en(cpu_clk_en), .dbg_clk_en(dbg_clk_en), .reg_full_en(reg_full_en),
    .analog_stop_ok(analog_stop_ok), .io_hold(io_hold), .illegal_rst(illegal_rst),
    .wake_rst_vec(wake_rst_vec), .wake_irq_vec(wake_irq_vec)
  );

  typedef struct {
    logic [8:0] vals;   // mode[2:0], cpu, dbg, reg, ana, hold, spare
    logic [2:0] pulses; // illegal, wake_rst, wake_irq
    string      tag;
  } exp_t;

  exp_t sb[$];
  int checks = 0, fails = 0;
  logic [2:0] m = 3'd0;
  bit done = 0;

  function automatic logic [8:0] outs_for(logic [2:0] md);
    logic run;
    run = (md == 3'd0);
    return {md, run, run | (md == 3'd3), run | md == 3'd3 | md == 3'd2,
            md == 3'd2, !run, 1'b0};
  endfunction

  // Drive one cycle of inputs and queue the expected result after the next edge.
  task automatic step(input logic sx, input logic [4:0] cfg, input logic rp,
                      input logic [N_INT-1:0] ii, input logic [N_PIN-1:0] pi,
                      input string tag);
    exp_t e;
    logic ill, wr, wi;
    @(negedge clk);
    stop_exec = sx; {se, de, le, ls, pd} = cfg; reset_pin = rp;
    int_irq = ii; pin_irq = pi;
    ill = 0; wr = 0; wi = 0;
    if (m == 3'd0) begin
      if (sx) begin
        if (!cfg[4]) ill = 1;
        else if (cfg[3]) m = 3'd3;
        else if (cfg[2] & cfg[1]) m = 3'd2;
        else m = cfg[0] ? 3'd4 : 3'd1;
      end
    end else if (m == 3'd4) begin
      if (rp || pi != 0) begin m = 3'd0; wr = 1; end
    end else if (rp) begin
      m = 3'd0; wr = 1;
    end else if (ii != 0 || pi != 0) begin
      m = 3'd0; wi = 1;
    end
    e.vals = outs_for(m); e.pulses = {ill, wr, wi}; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle(input string tag);
    step(1'b0, {se, de, le, ls, pd}, 1'b0, '0, '0, tag);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk); #2;
      if (sb.size() > 0) begin
        exp_t e;
        logic [8:0] av;
        logic [2:0] ap;
        e = sb.pop_front();
        av = {mode_o, cpu_clk_en, dbg_clk_en, reg_full_en, analog_stop_ok, io_hold, 1'b0};
        ap = {illegal_rst, wake_rst_vec, wake_irq_vec};
        checks++;
        if (av !== e.vals || ap !== e.pulses) begin
          fails++;
          $display("FAIL %s: outs=%b pulses=%b expected outs=%b pulses=%b",
                   e.tag, av, ap, e.vals, e.pulses);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : driver
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    // R5 reset state
    idle("R5 reset state");
    // R1 illegal
    step(1'b1, 5'b01111, 1'b0, '0, '0, "R1 illegal reset");
    idle("R1 pulse ends");
    // R2 debug variant, R6 later cfg changes and strobes ignored
    step(1'b1, 5'b11001, 1'b0, '0, '0, "R2 debug stop3");
    step(1'b1, 5'b00110, 1'b0, '0, '0, "R6 strobe while stopped");
    idle("R6 cfg change ignored");
    step(1'b0, 5'b00110, 1'b0, 5'b00100, '0, "R7 internal irq wake");
    idle("R7 back in run");
    // R3 regulator variant, pin wake
    step(1'b1, 5'b10111, 1'b0, '0, '0, "R3 regulator stop3");
    idle("R10 held in stop");
    step(1'b0, 5'b10111, 1'b0, '0, 3'b001, "R7 pin irq wake");
    // R4 plain stop3, reset priority
    step(1'b1, 5'b10100, 1'b0, '0, '0, "R4 plain stop3");
    step(1'b0, 5'b10100, 1'b1, 5'b11111, 3'b111, "R8 reset beats irqs");
    // R4 stop2, R9 internal irqs ignored
    step(1'b1, 5'b10011, 1'b0, '0, '0, "R4 stop2 entry");
    step(1'b0, 5'b10011, 1'b0, 5'b11111, '0, "R9 int irq ignored");
    for (int i = 0; i < N_INT; i++)
      step(1'b0, 5'b10011, 1'b0, N_INT'(1) << i, '0, "R9 single int ignored");
    step(1'b0, 5'b10011, 1'b0, '0, 3'b100, "R9 pin wake reset vector");
    step(1'b1, 5'b10001, 1'b0, '0, '0, "R4 stop2 again");
    step(1'b0, 5'b10001, 1'b1, '0, '0, "R9 reset pin wake");
    // Every configuration combination
    for (int c = 0; c < 32; c++) begin
      step(1'b1, 5'(c), 1'b0, '0, '0, "R2 R3 R4 R1 priority sweep");
      idle("R10 sweep hold");
      step(1'b0, 5'(c), 1'b1, '0, '0, "R8 sweep wake");
    end
    for (int p = 0; p < N_PIN; p++) begin
      step(1'b1, 5'b10000, 1'b0, '0, '0, "R4 stop3 for pin line");
      step(1'b0, 5'b10000, 1'b0, '0, N_PIN'(1) << p, "R7 each pin line");
    end
    idle("R5 final run");
    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule